// File: doc/BRIEF.md
# Configurable Expected Code-Symbol Generator

This block supplies a soft-decision convolutional decoder with the code symbols that an encoder would have sent on every trellis branch. For each trellis state and each assumed input bit it presents, all at once, the parity symbols that the encoder's shift register would produce. The code rate (1/2, 1/3 or 1/4), the constraint length (3 to 9) and up to four generator polynomials are all set while the block runs. None of these symbols is stored. Each one is computed from the state number and the current polynomials.

A configuration stage takes the raw polynomials, each written in its own constraint length, and moves them into a fixed nine-tap layout. The input tap goes to the top position, the state taps stay at the bottom, and any tap beyond the active length is cleared. Polynomials that the selected rate does not use are cleared as well. The normalised set is captured only when the load strobe is high. The generator then works from it in three steps:

- It computes the symbols of every even state from the upper taps.
- It obtains each odd state's symbols by toggling the even neighbour's symbols with the tap that sees the state's lowest bit.
- It flags the states that lie above the active state count as inactive.

Top module: `conv_symbol_gen`

## Requirements
- R1: Rate code 0 selects two symbols per branch, code 1 selects three, and codes 2 and 3 both select four. Every symbol index at or above the selected count reads 0 for all states and both input bits.
- R2: The loaded constraint length is clamped into the range 3 to 9. After a load, `state_active[s]` is 1 exactly when s is below 2^(K-1).
- R3: Polynomial j occupies `cfg_poly[9j+8:9j]`. Raw bit K-1 is the tap on the input bit, and raw bit i (for i < K-1) is the tap on state bit i. Raw bits at K and above have no effect.
- R4: For an active state s and input bit b, symbol j is the XOR over all i < K of (raw bit i of polynomial j AND register bit i). The register holds b at position K-1 and s[K-2:0] below it.
- R5: For every pair of states 2m and 2m+1, with either input bit, the symbol of the odd state equals the symbol of the even state XOR bit 0 of that symbol's normalised polynomial.
- R6: Rate, length and polynomials are sampled at a rising clock edge where `cfg_load` is 1, and the outputs reflect them after that edge. Changes on the configuration inputs while `cfg_load` is 0 leave every output unchanged.
- R7: After a synchronous active-low reset, the rate is 1/2, K is 3 and all polynomials are zero. All symbols therefore read 0 and only states 0 to 3 are active.
- R8: Symbol j of state s under input b appears at bit ((s*2+b)*4+j) of `exp_sym`.
- R9: State 0 with input bit 0 yields all-zero symbols under every configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_load | input | 1 | Strobe that captures a new configuration |
| cfg_rate | input | 2 | Rate code: 0 for 1/2, 1 for 1/3, 2 or 3 for 1/4 |
| cfg_k | input | 4 | Constraint length, clamped to 3..9 |
| cfg_poly | input | 36 | Four raw generator polynomials, 9 bits each |
| exp_sym | output | 2048 | Expected symbols, indexed by state, input bit and symbol |
| state_active | output | 256 | One flag per state, set when the state exists at the active K |

## Verification
The outputs come straight from the configuration register through gates only, so a captured wrong rate, length or tap shows up in the cycle right after the load strobe. A wrong rate shows as nonzero symbols in the unused symbol positions. A wrong length shows as the wrong number of active state flags. A wrong tap shows as a symbol mismatch on roughly half of the active states. A fault in the odd-state correction breaks the parity relation between neighbouring states even when the even states are correct. A fault in load gating shows as outputs that move while the strobe is low.

// File: rtl/cgen_pkg.sv
// Package: shared constants and helpers for the expected code-symbol generator.
// Assumes at most four symbols per branch and a constraint length of at most 15.
package cgen_pkg;
    localparam int MAX_K_DEF = 9;
    localparam int MIN_K_DEF = 3;
    localparam int NSYM_DEF  = 4;

    typedef enum logic [1:0] {
        RATE_HALF    = 2'd0,
        RATE_THIRD   = 2'd1,
        RATE_QUARTER = 2'd2,
        RATE_ALT_Q   = 2'd3
    } rate_code_e;

    // Number of symbols per branch selected by a rate code, capped at nsym.
    function automatic int active_symbols(input logic [1:0] code, input int nsym);
        int n;
        n = int'(code) + 2;
        if (n > nsym) n = nsym;
        return n;
    endfunction

    // Clamp a requested constraint length into [kmin, kmax].
    function automatic int clamp_k(input int k, input int kmin, input int kmax);
        if (k < kmin) return kmin;
        if (k > kmax) return kmax;
        return k;
    endfunction
endpackage

// File: rtl/cgen_cfg.sv
// Configuration stage. It clamps the constraint length and moves each raw
// polynomial into a MAX_K-wide layout: the input tap goes to the top bit,
// state taps stay in place, and unused taps and unused polynomials become zero.
// The result is registered on cfg_load only.
// Assumes: raw polynomial j uses bits [K-1:0] of its MAX_K-bit field.
module cgen_cfg
    import cgen_pkg::*;
#(
    parameter int MAX_K = MAX_K_DEF,
    parameter int MIN_K = MIN_K_DEF,
    parameter int NSYM  = NSYM_DEF,
    localparam int KW   = $clog2(MAX_K + 1),
    localparam int PW   = NSYM * MAX_K
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_load,
    input  logic [1:0]    cfg_rate,
    input  logic [KW-1:0] cfg_k,
    input  logic [PW-1:0] cfg_poly,
    output logic [PW-1:0] norm_q,
    output logic [KW-1:0] k_q
);
    logic [PW-1:0] norm_d;
    logic [KW-1:0] k_d;

    // Normalise all polynomials for the requested rate and length.
    always_comb begin
        int kc;
        int nact;
        kc     = clamp_k(int'(cfg_k), MIN_K, MAX_K);
        nact   = active_symbols(cfg_rate, NSYM);
        k_d    = KW'(kc);
        norm_d = '0;
        for (int j = 0; j < NSYM; j++) begin
            if (j < nact) begin
                for (int i = 0; i < MAX_K - 1; i++) begin
                    if (i < kc - 1) norm_d[j*MAX_K + i] = cfg_poly[j*MAX_K + i];
                end
                for (int i = 0; i < MAX_K; i++) begin
                    if (i == kc - 1) norm_d[j*MAX_K + MAX_K - 1] = cfg_poly[j*MAX_K + i];
                end
            end
        end
    end

    // Hold the normalised configuration; update only on the load strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            norm_q <= '0;
            k_q    <= KW'(MIN_K);
        end else if (cfg_load) begin
            norm_q <= norm_d;
            k_q    <= k_d;
        end
    end
endmodule

// File: rtl/cgen_active.sv
// State-validity flags. A state is active when its number is below
// 2^(K-1) for the registered constraint length.
// Assumes: k_q is already clamped into [MIN_K, MAX_K].
module cgen_active #(
    parameter int MAX_K = 9,
    localparam int KW   = $clog2(MAX_K + 1),
    localparam int SW   = MAX_K - 1,
    localparam int NST  = 1 << SW
) (
    input  logic [KW-1:0]  k_q,
    output logic [NST-1:0] state_active
);
    logic [SW:0] limit;

    // One-hot limit value 2^(K-1).
    always_comb begin
        for (int i = 0; i <= SW; i++) limit[i] = (i == int'(k_q) - 1);
    end

    for (genvar s = 0; s < NST; s++) begin : g_flag
        assign state_active[s] = ((SW+1)'(s) < limit);
    end
endmodule

// File: rtl/cgen_even.sv
// Symbol generator for one even state. It uses only the upper taps of each
// normalised polynomial, because the LSB of an even state is zero. It produces
// the symbols for both input bits, at index b*NSYM + j.
// Assumes: upper-tap vector j holds normalised bits [MAX_K-1:1].
module cgen_even #(
    parameter int MAX_K = 9,
    parameter int NSYM  = 4,
    parameter int STATE = 0,
    localparam int SW   = MAX_K - 1,
    localparam int UW   = MAX_K - 1
) (
    input  logic [NSYM*UW-1:0] upper_taps,
    output logic [2*NSYM-1:0]  sym
);
    localparam logic [SW-1:0] SV = SW'(STATE);

    for (genvar b = 0; b < 2; b++) begin : g_bit
        for (genvar j = 0; j < NSYM; j++) begin : g_sym
            // Parity of the upper register contents {b, state[SW-1:1]}.
            assign sym[b*NSYM + j] =
                ^(upper_taps[j*UW +: UW] & {1'(b), SV[SW-1:1]});
        end
    end
endmodule

// File: rtl/conv_symbol_gen.sv
// Top level of the expected code-symbol generator. It registers a
// normalised configuration, computes the symbols of the even states, and
// derives each odd state's symbols from its even neighbour by toggling with
// bit 0 of each polynomial. Output bit ((s*2+b)*NSYM + j) holds symbol j.
// Assumes: outputs are purely combinational from the configuration register.
module conv_symbol_gen
    import cgen_pkg::*;
#(
    parameter int MAX_K = MAX_K_DEF,
    parameter int MIN_K = MIN_K_DEF,
    parameter int NSYM  = NSYM_DEF,
    localparam int KW   = $clog2(MAX_K + 1),
    localparam int SW   = MAX_K - 1,
    localparam int NST  = 1 << SW,
    localparam int PW   = NSYM * MAX_K,
    localparam int UW   = MAX_K - 1,
    localparam int OW   = NST * 2 * NSYM
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_load,
    input  logic [1:0]     cfg_rate,
    input  logic [KW-1:0]  cfg_k,
    input  logic [PW-1:0]  cfg_poly,
    output logic [OW-1:0]  exp_sym,
    output logic [NST-1:0] state_active
);
    logic [PW-1:0]      norm_q;
    logic [KW-1:0]      k_q;
    logic [NSYM*UW-1:0] upper_taps;
    logic [NSYM-1:0]    lsb_tap;

    cgen_cfg #(.MAX_K(MAX_K), .MIN_K(MIN_K), .NSYM(NSYM)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_load (cfg_load),
        .cfg_rate (cfg_rate),
        .cfg_k    (cfg_k),
        .cfg_poly (cfg_poly),
        .norm_q   (norm_q),
        .k_q      (k_q)
    );

    cgen_active #(.MAX_K(MAX_K)) u_active (
        .k_q          (k_q),
        .state_active (state_active)
    );

    // Split each polynomial into its upper taps and its state-LSB tap.
    for (genvar j = 0; j < NSYM; j++) begin : g_split
        assign upper_taps[j*UW +: UW] = norm_q[j*MAX_K + 1 +: UW];
        assign lsb_tap[j]             = norm_q[j*MAX_K];
    end

    for (genvar e = 0; e < NST/2; e++) begin : g_pair
        logic [2*NSYM-1:0] even_sym;

        cgen_even #(.MAX_K(MAX_K), .NSYM(NSYM), .STATE(2*e)) u_even (
            .upper_taps (upper_taps),
            .sym        (even_sym)
        );

        // Even state takes its symbols directly; odd state toggles by the LSB tap.
        assign exp_sym[(2*e)*2*NSYM   +: 2*NSYM] = even_sym;
        assign exp_sym[(2*e+1)*2*NSYM +: 2*NSYM] = even_sym ^ {lsb_tap, lsb_tap};
    end
endmodule

// File: rtl/cgen_chk.sv
// Checker for conv_symbol_gen. It keeps a shadow copy of the rate and
// length taken from the load strobe, and checks the outputs against the
// rate limits, the active-state count, the odd/even pairing, load gating and
// the zero state. It is attached to the top module with bind.
module cgen_chk #(
    parameter int MAX_K = 9,
    parameter int MIN_K = 3,
    parameter int NSYM  = 4,
    localparam int KW   = $clog2(MAX_K + 1),
    localparam int SW   = MAX_K - 1,
    localparam int NST  = 1 << SW,
    localparam int OW   = NST * 2 * NSYM
) (
    input logic           clk,
    input logic           rst_n,
    input logic           cfg_load,
    input logic [1:0]     cfg_rate,
    input logic [KW-1:0]  cfg_k,
    input logic [OW-1:0]  exp_sym,
    input logic [NST-1:0] state_active
);
    logic [1:0]       rate_sh;
    int               k_sh;
    logic             hi_any;
    logic             pair_bad;
    logic [2*NSYM-1:0] ref_x;

    // Shadow of the accepted configuration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate_sh <= 2'd0;
            k_sh    <= MIN_K;
        end else if (cfg_load) begin
            rate_sh <= cfg_rate;
            k_sh    <= (int'(cfg_k) < MIN_K) ? MIN_K :
                       (int'(cfg_k) > MAX_K) ? MAX_K : int'(cfg_k);
        end
    end

    // Any set symbol at an index beyond the active count.
    always_comb begin
        int nact;
        nact   = int'(rate_sh) + 2;
        if (nact > NSYM) nact = NSYM;
        hi_any = 1'b0;
        for (int s = 0; s < NST*2; s++)
            for (int j = 0; j < NSYM; j++)
                if (j >= nact) hi_any = hi_any | exp_sym[s*NSYM + j];
    end

    // Every odd/even pair must differ by the same tap pattern.
    always_comb begin
        ref_x    = exp_sym[0 +: 2*NSYM] ^ exp_sym[2*NSYM +: 2*NSYM];
        pair_bad = 1'b0;
        for (int m = 1; m < NST/2; m++)
            if ((exp_sym[(2*m)*2*NSYM +: 2*NSYM] ^ exp_sym[(2*m+1)*2*NSYM +: 2*NSYM]) != ref_x)
                pair_bad = 1'b1;
    end

    assert_unused_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !hi_any);

    assert_active_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(state_active) == (1 << (k_sh - 1)));

    assert_odd_even_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !pair_bad);

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_load |=> ($stable(exp_sym) && $stable(state_active)));

    assert_zero_state_R9: assert property (@(posedge clk) disable iff (!rst_n)
        exp_sym[NSYM-1:0] == '0);
endmodule

bind conv_symbol_gen cgen_chk #(.MAX_K(MAX_K), .MIN_K(MIN_K), .NSYM(NSYM)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_load     (cfg_load),
    .cfg_rate     (cfg_rate),
    .cfg_k        (cfg_k),
    .exp_sym      (exp_sym),
    .state_active (state_active)
);

// File: tb/sim_conv_symbol_gen.sv
module sim_conv_symbol_gen;
    localparam int CLK_PERIOD = 10;
    localparam int NST = 256;
    localparam int OW  = NST * 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_load = 1'b0;
    logic [1:0]    cfg_rate = 2'd0;
    logic [3:0]    cfg_k = 4'd3;
    logic [35:0]   cfg_poly = '0;
    logic [OW-1:0] exp_sym;
    logic [NST-1:0] state_active;

    int checks = 0;
    int errors = 0;

    // Shadow of the last configuration the bench loaded.
    logic [35:0] cur_poly = '0;
    int          cur_k = 3;
    int          cur_rate = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    conv_symbol_gen u0 (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_rate(cfg_rate),
        .cfg_k(cfg_k), .cfg_poly(cfg_poly), .exp_sym(exp_sym),
        .state_active(state_active)
    );

    // Reference symbol from the raw polynomial and the register contents.
    function automatic bit ref_sym(logic [35:0] p, int k, int rate, int s, int b, int j);
        int nact;
        bit acc;
        bit rb;
        nact = rate + 2;
        if (nact > 4) nact = 4;
        if (j >= nact) return 1'b0;
        acc = 1'b0;
        for (int i = 0; i < k; i++) begin
            rb  = (i == k - 1) ? b[0] : ((s >> i) & 1) != 0;
            acc = acc ^ (p[j*9 + i] & rb);
        end
        return acc;
    endfunction

    function automatic int eff_k(int k);
        if (k < 3) return 3;
        if (k > 9) return 9;
        return k;
    endfunction

    task automatic load_cfg(int rate, int k, logic [35:0] p);
        @(negedge clk);
        cfg_rate = 2'(rate); cfg_k = 4'(k); cfg_poly = p; cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
        cur_poly = p; cur_k = eff_k(k); cur_rate = rate;
    endtask

    // R4 R8 R1: compare every symbol of every active state against the reference.
    task automatic check_syms(string tag);
        int bad;
        int s_b, b_b, j_b;
        bit got_b, exp_b;
        bad = 0; s_b = 0; b_b = 0; j_b = 0; got_b = 0; exp_b = 0;
        for (int s = 0; s < (1 << (cur_k - 1)); s++)
            for (int b = 0; b < 2; b++)
                for (int j = 0; j < 4; j++) begin
                    bit e;
                    e = ref_sym(cur_poly, cur_k, cur_rate, s, b, j);
                    if (exp_sym[(s*2 + b)*4 + j] !== e) begin
                        if (bad == 0) begin
                            s_b = s; b_b = b; j_b = j;
                            got_b = exp_sym[(s*2 + b)*4 + j]; exp_b = e;
                        end
                        bad++;
                    end
                end
        checks++;
        if (bad != 0) begin
            errors++;
            $display("FAIL %s symbols s=%0d b=%0d j=%0d actual %0d expected %0d (%0d mismatches)",
                     tag, s_b, b_b, j_b, got_b, exp_b, bad);
        end
    endtask

    // R2: active flags must match 2^(K-1).
    task automatic check_active(string tag);
        logic [NST-1:0] e;
        for (int s = 0; s < NST; s++) e[s] = (s < (1 << (cur_k - 1)));
        checks++;
        if (state_active !== e) begin
            errors++;
            $display("FAIL %s active actual %0d expected %0d states",
                     tag, $countones(state_active), $countones(e));
        end
    endtask

    // R1: symbol indices beyond the rate must be zero in every state.
    task automatic check_unused(string tag);
        int nact;
        int ones;
        nact = cur_rate + 2;
        if (nact > 4) nact = 4;
        ones = 0;
        for (int s = 0; s < NST*2; s++)
            for (int j = nact; j < 4; j++) ones += int'(exp_sym[s*4 + j]);
        checks++;
        if (ones != 0) begin
            errors++;
            $display("FAIL %s unused symbols set actual %0d expected 0", tag, ones);
        end
    endtask

    // R5: odd state equals even neighbour toggled by bit 0 of each normalised polynomial.
    task automatic check_pairs(string tag);
        int bad;
        int nact;
        nact = cur_rate + 2;
        if (nact > 4) nact = 4;
        bad = 0;
        for (int m = 0; m < NST/2; m++)
            for (int b = 0; b < 2; b++)
                for (int j = 0; j < 4; j++) begin
                    bit t;
                    t = (j < nact) && (cur_k > 1) ? cur_poly[j*9] : 1'b0;
                    if ((exp_sym[((2*m)*2 + b)*4 + j] ^ exp_sym[((2*m+1)*2 + b)*4 + j]) !== t)
                        bad++;
                end
        checks++;
        if (bad != 0) begin
            errors++;
            $display("FAIL %s R5 pair mismatches actual %0d expected 0", tag, bad);
        end
    endtask

    task automatic check_all(string tag);
        check_syms(tag);
        check_active(tag);
        check_unused(tag);
        check_pairs(tag);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [OW-1:0] snap_sym;
        logic [NST-1:0] snap_act;
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R7: reset state, all symbols zero and four states active.
        checks++;
        if (exp_sym !== '0) begin
            errors++;
            $display("FAIL R7 reset symbols actual %0d ones expected 0", $countones(exp_sym));
        end
        check_active("R7");

        // R2 R4: smallest and largest lengths with all taps on.
        load_cfg(2, 3, {36{1'b1}});   check_all("R2_R4_k3");
        load_cfg(2, 9, {36{1'b1}});   check_all("R2_R4_k9");
        // R2: clamping below and above the range.
        load_cfg(1, 1, 36'h1_2345_6789); check_all("R2_clamp_low");
        load_cfg(0, 15, 36'hF_EDCB_A987); check_all("R2_clamp_high");
        // R1: rate code 3 behaves as 1/4, and rate 1/2 clears symbols 2 and 3.
        load_cfg(3, 7, 36'hA_5A5A_5A5A); check_all("R1_code3");
        load_cfg(0, 7, {36{1'b1}});       check_all("R1_half");
        // R3: bits above K-1 in a raw polynomial have no effect (only upper junk set).
        load_cfg(2, 4, {4{9'b111110000}}); check_all("R3_upper_bits");
        checks++;
        if (exp_sym !== '0) begin
            errors++;
            $display("FAIL R3 upper bits actual %0d ones expected 0", $countones(exp_sym));
        end
        // R5: only the state-LSB tap set.
        load_cfg(2, 6, {4{9'b000000001}}); check_all("R5_lsb_only");

        // R6: inputs change with no load; outputs must hold the old configuration.
        load_cfg(2, 8, 36'h5_1234_ABCD);
        snap_sym = exp_sym; snap_act = state_active;
        cfg_rate = 2'd0; cfg_k = 4'd3; cfg_poly = {36{1'b1}};
        repeat (3) @(negedge clk);
        checks++;
        if (exp_sym !== snap_sym || state_active !== snap_act) begin
            errors++;
            $display("FAIL R6 outputs changed without load actual %0d ones expected %0d ones",
                     $countones(exp_sym), $countones(snap_sym));
        end
        check_all("R6_held");

        // R9 R8: random configurations.
        for (int n = 0; n < 24; n++) begin
            int r, k;
            logic [35:0] p;
            r = int'($urandom_range(0, 3));
            k = int'($urandom_range(0, 15));
            p = {$urandom(), $urandom()} & 36'hF_FFFF_FFFF;
            load_cfg(r, k, p);
            check_all("R8_random");
            checks++;
            if (exp_sym[3:0] !== 4'b0) begin
                errors++;
                $display("FAIL R9 zero state actual %0h expected 0", exp_sym[3:0]);
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule